// File: doc/BRIEF.md
# Phase-Offset Sine Amplitude Generator

This block sits behind the phase accumulator of a numerically controlled oscillator. Each clock it takes the accumulator's 8-bit quantized phase, adds a phase-offset word and registers the 8-bit sum. It then converts that modulated phase into an 8-bit sine amplitude. Changing the offset word moves the carrier's phase by an exact number of 1/256 steps, so the block can produce M-ary phase modulation without touching the accumulator.

The offset word is written from a slower, unrelated domain. The data is latched on the rising edge of an active-low write strobe. The strobe is then resynchronized into the clock domain, and the new word is handed to the adder only after that. The amplitude comes from a table that holds only the first quarter of a sine wave, with 64 unsigned 7-bit magnitudes. Two steps rebuild the full 256-step period from that quarter. The table address is mirrored in the second and fourth quarters, and the half-cycle sign bit is carried through as the output's top bit.

Top module: `pm_sine_lut`

## Requirements
- R1: While `rstN` is low, `modPhaseOut` and `ampOut` read 0 and the stored offset word is cleared to 0.
- R2: The offset word is `modWordIn` as sampled on a rising edge of `modWrN`. A change of `modWordIn` at any other time has no effect, whether the strobe is high or held low.
- R3: The offset word stays unchanged except after a strobe rising edge. The new word is first visible in `modPhaseOut` after the fourth rising clock edge that follows the strobe's rising edge. After the third such edge, `modPhaseOut` still uses the old word.
- R4: After each rising clock edge, `modPhaseOut` equals (offset word + `phaseIn`) modulo 256, where `phaseIn` is the value sampled at that edge.
- R5: Bit 7 of `ampOut` equals bit 7 of the modulated phase it was computed from. A value of 1 marks the negative half cycle, and the output is sign-magnitude.
- R6: Bits 6:0 of `ampOut` are the table entry at address p[5:0] when p[6]=0, and at the bitwise inverse of p[5:0] when p[6]=1, where p is the modulated phase. For example, phases 0x20 and 0x5F both read address 32.
- R7: Table entry k (0..63) equals round(127·sin((k+0.5)·π/128)). Entry 0 is 2, entry 32 is 91 and entry 63 is 127.
- R8: `ampOut` reflects the `phaseIn` value sampled three rising clock edges earlier: one edge for the sum, one for the address and one for the table output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseIn | input | 8 | Quantized phase from the accumulator |
| modWordIn | input | 8 | Phase-offset word to be written |
| modWrN | input | 1 | Active-low write strobe for the offset word; rising edge latches it |
| modPhaseOut | output | 8 | Registered modulated phase |
| ampOut | output | 8 | Sign-magnitude sine amplitude |

## Verification
The modulated phase is due one clock edge after `phaseIn` is sampled, and the amplitude three edges after it. A new offset word reaches `modPhaseOut` on the fourth clock edge after the strobe rises. The bench drives all inputs just after the falling clock edge and samples just after the next falling edge. Its reference model keeps a three-deep history of predicted phases and a countdown that applies a pending offset word at the edge where the hardware loads it. Every sample is therefore compared with the value due in that exact cycle. Directed cases check that the result is not yet present one edge early, for both the amplitude path and the word-load path.

// File: rtl/pm_sine_pkg.sv
package pm_sine_pkg;

  // strobes from the write-strobe control to the datapath
  typedef struct packed {
    logic loadWord;   // one-clock pulse: take the latched offset word
  } ctrl_strobe_t;

  // rounded quarter-wave magnitude for table index k, sampled at half steps
  function automatic int quarterSine(input int k, input int addrW, input int magW);
    real piVal;
    real fullScale;
    real angle;
    real mag;
    piVal     = 3.14159265358979;
    fullScale = real'((1 << magW) - 1);
    angle     = (real'(k) + 0.5) * piVal / (2.0 * real'(1 << addrW));
    mag       = fullScale * $sin(angle);
    return $rtoi(mag + 0.5);
  endfunction

endpackage

// File: rtl/pm_sine_rom.sv
module pm_sine_rom
  import pm_sine_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int MAG_W  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [MAG_W-1:0]  mag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [MAG_W-1:0] sineTab [DEPTH];

  // contents computed at elaboration, one entry per quarter-wave step
  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    assign sineTab[k] = MAG_W'(quarterSine(k, ADDR_W, MAG_W));
  end

  assign mag = sineTab[addr];

endmodule

// File: rtl/pm_sine_ctrl.sv
module pm_sine_ctrl
  import pm_sine_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modWrN,
  input  logic [WORD_W-1:0] modWordIn,
  output ctrl_strobe_t      ctrl,
  output logic [WORD_W-1:0] heldWord
);

  // word latched by the strobe itself, outside the clock domain
  always_ff @(posedge modWrN or negedge rstN) begin
    if (!rstN) heldWord <= '0;
    else       heldWord <= modWordIn;
  end

  // strobe resynchronizer; idle level is high so reset creates no edge
  logic [SYNC_STAGES-1:0] wrSyncChain;
  logic                   wrLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSyncChain <= '1;
      wrLast      <= 1'b1;
    end else begin
      wrSyncChain <= {wrSyncChain[SYNC_STAGES-2:0], modWrN};
      wrLast      <= wrSyncChain[SYNC_STAGES-1];
    end
  end

  assign ctrl.loadWord = wrSyncChain[SYNC_STAGES-1] & ~wrLast;

  // R3
  load_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadWord |=> !ctrl.loadWord);

endmodule

// File: rtl/pm_sine_datapath.sv
module pm_sine_datapath
  import pm_sine_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int MAG_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       ctrl,
  input  logic [PHASE_W-1:0] heldWord,
  input  logic [PHASE_W-1:0] phaseIn,
  output logic [PHASE_W-1:0] modPhaseOut,
  output logic [MAG_W:0]     ampOut
);
  localparam int ADDR_W = PHASE_W - 2;
  localparam int QUAD_B = PHASE_W - 2;   // quarter select: mirror the address
  localparam int SIGN_B = PHASE_W - 1;   // half select: negative half cycle

  logic [PHASE_W-1:0] phaseWord;
  logic [PHASE_W-1:0] modPhase;
  logic [ADDR_W-1:0]  tableAddr;
  logic               signDly;
  logic [MAG_W-1:0]   romMag;

  // synchronous offset word, updated only on the control's load pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phaseWord <= '0;
    else if (ctrl.loadWord) phaseWord <= heldWord;
  end

  // stage 1: modulo-2^PHASE_W phase offset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modPhase <= '0;
    else       modPhase <= phaseWord + phaseIn;
  end

  assign modPhaseOut = modPhase;

  // stage 2: mirrored table address, sign delayed alongside
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tableAddr <= '0;
      signDly   <= 1'b0;
    end else begin
      tableAddr <= modPhase[QUAD_B] ? ~modPhase[ADDR_W-1:0] : modPhase[ADDR_W-1:0];
      signDly   <= modPhase[SIGN_B];
    end
  end

  pm_sine_rom #(
    .ADDR_W(ADDR_W),
    .MAG_W (MAG_W)
  ) u_rom (
    .addr(tableAddr),
    .mag (romMag)
  );

  // stage 3: sign-magnitude amplitude
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ampOut <= '0;
    else       ampOut <= {signDly, romMag};
  end

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadWord |=> $stable(phaseWord));

  // R2
  word_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadWord |=> (phaseWord == $past(heldWord)));

  // R5
  sign_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    ampOut[MAG_W] == $past(modPhase[SIGN_B], 2));

endmodule

// File: rtl/pm_sine_lut.sv
module pm_sine_lut
  import pm_sine_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int MAG_W   = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic [PHASE_W-1:0] modWordIn,
  input  logic               modWrN,
  output logic [PHASE_W-1:0] modPhaseOut,
  output logic [MAG_W:0]     ampOut
);

  ctrl_strobe_t       ctrl;
  logic [PHASE_W-1:0] heldWord;

  pm_sine_ctrl #(
    .WORD_W     (PHASE_W),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modWrN   (modWrN),
    .modWordIn(modWordIn),
    .ctrl     (ctrl),
    .heldWord (heldWord)
  );

  pm_sine_datapath #(
    .PHASE_W(PHASE_W),
    .MAG_W  (MAG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .heldWord   (heldWord),
    .phaseIn    (phaseIn),
    .modPhaseOut(modPhaseOut),
    .ampOut     (ampOut)
  );

endmodule

// File: tb/sim_pm_sine_lut.sv
module sim_pm_sine_lut;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] phaseIn;
  logic [7:0] modWordIn;
  logic       modWrN;
  logic [7:0] modPhaseOut;
  logic [7:0] ampOut;

  always #10 clk = ~clk;   // 50 MHz

  pm_sine_lut u0 (
    .clk        (clk),
    .rstN       (rstN),
    .phaseIn    (phaseIn),
    .modWordIn  (modWordIn),
    .modWrN     (modWrN),
    .modPhaseOut(modPhaseOut),
    .ampOut     (ampOut)
  );

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  // reference model state
  logic [7:0] mdlWord;
  logic [7:0] pendWord;
  int         pendCnt;
  logic       prevWr;
  logic [7:0] mpH0, mpH1, mpH2;

  // expected amplitude from a modulated phase (R5, R6, R7)
  function automatic logic [7:0] expAmp(input logic [7:0] p);
    logic [5:0] a;
    real        x;
    int         m;
    a = p[6] ? ~p[5:0] : p[5:0];
    x = 127.0 * $sin((real'(a) + 0.5) * 3.14159265358979 / 128.0);
    m = $rtoi(x + 0.5);
    return {p[7], m[6:0]};
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, model the rising edge, sample at the next fall
  task automatic step(input logic [7:0] pin, input logic wr, input logic [7:0] wd);
    phaseIn   = pin;
    modWordIn = wd;
    #2;
    modWrN = wr;
    if (wr && !prevWr) begin
      pendWord = wd;
      pendCnt  = 3;
    end
    prevWr = wr;
    @(posedge clk);
    mpH2 = mpH1;
    mpH1 = mpH0;
    mpH0 = mdlWord + pin;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) mdlWord = pendWord;
    end
    @(negedge clk);
    check8("R4 modPhaseOut", modPhaseOut, mpH0);
    check8("R6 ampOut", ampOut, expAmp(mpH2));
  endtask

  task automatic holdCheck(input logic [7:0] p, input logic [7:0] exp, input string tag);
    repeat (3) step(p, prevWr, modWordIn);
    check8(tag, ampOut, exp);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; modWrN = 1'b1; phaseIn = 8'h00; modWordIn = 8'h00;
    mdlWord = 8'h00; pendWord = 8'h00; pendCnt = 0; prevWr = 1'b1;
    mpH0 = 8'h00; mpH1 = 8'h00; mpH2 = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check8("R1 reset modPhaseOut", modPhaseOut, 8'h00);
    check8("R1 reset ampOut", ampOut, 8'h00);
    rstN = 1'b1;

    // R8: amplitude arrives on the third edge, not earlier
    repeat (4) step(8'h00, 1'b1, 8'h00);
    check8("R1 offset word cleared", modPhaseOut, 8'h00);
    step(8'h40, 1'b1, 8'h00);
    check8("R8 edge1 amp", ampOut, 8'h02);
    step(8'h00, 1'b1, 8'h00);
    check8("R8 edge2 amp", ampOut, 8'h02);
    step(8'h00, 1'b1, 8'h00);
    check8("R8 edge3 amp", ampOut, 8'h7F);

    // R5 R6 R7 fixed points and mirroring
    holdCheck(8'h00, 8'h02, "R7 entry0");
    holdCheck(8'h3F, 8'h7F, "R7 entry63");
    holdCheck(8'h40, 8'h7F, "R6 mirror start q2");
    holdCheck(8'h7F, 8'h02, "R6 mirror end q2");
    holdCheck(8'h20, 8'h5B, "R7 entry32");
    holdCheck(8'h5F, 8'h5B, "R6 mirror of 32");
    holdCheck(8'h80, 8'h82, "R5 negative half");
    holdCheck(8'hC0, 8'hFF, "R5 R6 q4 peak");
    holdCheck(8'hBF, 8'hFF, "R5 q3 peak");

    // R3: word reaches modPhaseOut on the fourth edge after the strobe rise
    step(8'h00, 1'b0, 8'h55);
    step(8'h00, 1'b0, 8'h55);
    step(8'h00, 1'b1, 8'h55);   // rise, then edge 1
    step(8'h00, 1'b1, 8'h55);   // edge 2
    step(8'h00, 1'b1, 8'h55);   // edge 3
    check8("R3 old word after third edge", modPhaseOut, 8'h00);
    step(8'h00, 1'b1, 8'h55);   // edge 4
    check8("R3 new word after fourth edge", modPhaseOut, 8'h55);

    // R2: data changes without a rising strobe edge are ignored
    repeat (6) step(8'h00, 1'b1, 8'hAA);
    check8("R2 data change while high", modPhaseOut, 8'h55);
    repeat (3) step(8'h00, 1'b0, 8'h11);
    repeat (6) step(8'h00, 1'b0, 8'h22);
    check8("R2 held low no effect", modPhaseOut, 8'h55);
    repeat (6) step(8'h10, 1'b1, 8'h22);
    check8("R2 value at rise taken", modPhaseOut, 8'h32);

    // random phases mixed with random offset writes
    for (int n = 0; n < 800; n++) begin
      logic [7:0] pin;
      pin = 8'($urandom);
      if (n % 37 == 5 || n % 37 == 6) step(pin, 1'b0, 8'($urandom));
      else                             step(pin, 1'b1, modWordIn);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule